// File: doc/BRIEF.md
# Event-Qualified Up/Down Counter Controller

This block is a timer core whose actions are driven by event sources that software selects. Six event inputs feed it: four external trigger lines and two I/O pins, A and B. The block detects rising and falling edges on every input. An edge on pin A can be qualified by the present level of pin B, and an edge on pin B by the level of pin A. Together these give a vector of sixteen single-cycle events. Every input passes through a two-flop synchronizer before edge detection, so the whole block runs on the core clock.

Seven independent 16-bit masks pick which events drive each action: start, stop, clear, capture into channel A, capture into channel B, count up and count down. An action fires when any event selected in its mask occurs. When both count masks are zero, the 32-bit counter counts core clocks while it runs. Otherwise each selected up or down event moves it by one step. Pairing the cross-qualified pin edges in the up and down masks gives quadrature decoding.

A capture copies the counter into the capture register of that channel and raises a single-cycle flag. Register decoding, PWM generation and interrupt handling belong to the surrounding logic.

Top module: `evq_timer`

## Requirements
- R1: While `rst_ni` is low, `count_o`, `cap_a_o` and `cap_b_o` are zero, and `running_o`, `cap_a_flag_o` and `cap_b_flag_o` are low.
- R2: Mask bit 2*i selects a rising edge of `trig_i[i]` and bit 2*i+1 a falling edge, for i = 0 to 3. A set bit fires the action for that edge only.
- R3: Mask bits 8, 9, 10 and 11 select, in that order: pin A rising while B is low, A rising while B is high, A falling while B is low, and A falling while B is high.
- R4: Mask bits 12, 13, 14 and 15 select, in that order: pin B rising while A is low, B rising while A is high, B falling while A is low, and B falling while A is high.
- R5: A mask with several bits set fires its action on any one of the selected events. An event that is not selected has no effect.
- R6: While running, with both count masks zero, the counter increments by one on every clock.
- R7: With a nonzero count mask, each selected up event adds one and each selected down event subtracts one, modulo 2^32. Counting happens only while running.
- R8: When an up event and a down event occur in the same cycle, the counter does not change.
- R9: A start event sets `running_o`. A stop event clears it, and stop wins over start in the same cycle. While stopped, the counter holds.
- R10: A clear event sets the counter to zero whether the counter is running or stopped. Clear takes priority over a count in the same cycle.
- R11: A capture event copies the counter value from before that edge into `cap_a_o` or `cap_b_o` and pulses the flag of that channel for one cycle. The other channel is unchanged.
- R12: An input change made between clock edges takes effect at the third rising clock edge that follows it, not at the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 4 | External trigger inputs, index i gives mask bits 2i and 2i+1 |
| pin_a_i | input | 1 | I/O pin A level |
| pin_b_i | input | 1 | I/O pin B level |
| start_mask_i | input | 16 | Events that start counting |
| stop_mask_i | input | 16 | Events that stop counting |
| clear_mask_i | input | 16 | Events that clear the counter |
| cap_a_mask_i | input | 16 | Events that capture into channel A |
| cap_b_mask_i | input | 16 | Events that capture into channel B |
| up_mask_i | input | 16 | Events that count up |
| down_mask_i | input | 16 | Events that count down |
| count_o | output | 32 | Counter value |
| running_o | output | 1 | Counter is running |
| cap_a_o | output | 32 | Capture register A |
| cap_b_o | output | 32 | Capture register B |
| cap_a_flag_o | output | 1 | One-cycle pulse on a capture into A |
| cap_b_flag_o | output | 1 | One-cycle pulse on a capture into B |

## Verification
The main sweep sets one bit at a time in the up mask and then in the down mask. For each setting it raises all sixteen possible events one after another and expects exactly one step, on the matching event only. This tells apart a swapped edge polarity, a wrong trigger index, an inverted qualifier level and a swap between the A-qualified and B-qualified groups. Separate patterns then drive a two-bit mask, simultaneous up and down edges, a down step from zero, clock-mode counting, a clear arriving while counting, a start and stop on the same edge, and captures on each channel. These show that OR-ing, cancellation, wraparound, action priority and isolation between the capture channels are each implemented separately. A start edge checked two and three clocks after it is driven pins down the synchronizer latency.

// File: rtl/evq_pkg.sv
package evq_pkg;
  // decoded action strobes for one cycle
  typedef struct packed {
    logic start;
    logic stop;
    logic clear;
    logic cap_a;
    logic cap_b;
    logic up;
    logic down;
  } evq_act_t;

  localparam int unsigned NUM_ACT = 7;
  localparam int unsigned PIN_EV_W = 8;  // 4 qualified events per pin

  function automatic int unsigned mask_width(int unsigned n_trig);
    return 2 * n_trig + PIN_EV_W;
  endfunction
endpackage

// File: rtl/evq_sync.sv
module evq_sync #(
  parameter int unsigned W      = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/evq_edge_decode.sv
module evq_edge_decode #(
  parameter int unsigned N_TRIG = 4,
  localparam int unsigned MASK_W = evq_pkg::mask_width(N_TRIG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic              pin_a_i,
  input  logic              pin_b_i,
  output logic [MASK_W-1:0] ev_o
);
  localparam int unsigned PA = 2 * N_TRIG;  // first A-pin event
  localparam int unsigned PB = PA + 4;      // first B-pin event

  logic [N_TRIG-1:0] trig_q;
  logic              pa_q, pb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= '0;
      pa_q   <= 1'b0;
      pb_q   <= 1'b0;
    end else begin
      trig_q <= trig_i;
      pa_q   <= pin_a_i;
      pb_q   <= pin_b_i;
    end
  end

  for (genvar i = 0; i < N_TRIG; i++) begin : g_trig
    assign ev_o[2*i]   =  trig_i[i] & ~trig_q[i];
    assign ev_o[2*i+1] = ~trig_i[i] &  trig_q[i];
  end

  logic a_rise, a_fall, b_rise, b_fall;
  assign a_rise =  pin_a_i & ~pa_q;
  assign a_fall = ~pin_a_i &  pa_q;
  assign b_rise =  pin_b_i & ~pb_q;
  assign b_fall = ~pin_b_i &  pb_q;

  // order per pin: rise/other-low, rise/other-high, fall/other-low, fall/other-high
  assign ev_o[PA+0] = a_rise & ~pin_b_i;
  assign ev_o[PA+1] = a_rise &  pin_b_i;
  assign ev_o[PA+2] = a_fall & ~pin_b_i;
  assign ev_o[PA+3] = a_fall &  pin_b_i;
  assign ev_o[PB+0] = b_rise & ~pin_a_i;
  assign ev_o[PB+1] = b_rise &  pin_a_i;
  assign ev_o[PB+2] = b_fall & ~pin_a_i;
  assign ev_o[PB+3] = b_fall &  pin_a_i;
endmodule

// File: rtl/evq_mask_hit.sv
module evq_mask_hit #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] ev_i,
  output logic         hit_o
);
  assign hit_o = |(mask_i & ev_i);
endmodule

// File: rtl/evq_count_core.sv
module evq_count_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  evq_pkg::evq_act_t act_i,
  input  logic             clk_mode_i,
  output logic [CNT_W-1:0] count_o,
  output logic             running_o,
  output logic [CNT_W-1:0] cap_o  [2],
  output logic [1:0]       cap_flag_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             step_up, step_dn;

  assign step_up = clk_mode_i | (act_i.up & ~act_i.down);
  assign step_dn = ~clk_mode_i & act_i.down & ~act_i.up;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (act_i.stop)       run_q <= 1'b0;
      else if (act_i.start) run_q <= 1'b1;

      if (act_i.clear)            cnt_q <= '0;
      else if (run_q && step_up)  cnt_q <= cnt_q + ONE;
      else if (run_q && step_dn)  cnt_q <= cnt_q - ONE;
    end
  end

  logic [1:0] cap_hit;
  assign cap_hit = {act_i.cap_b, act_i.cap_a};

  for (genvar c = 0; c < 2; c++) begin : g_cap
    logic [CNT_W-1:0] cap_q;
    logic             flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cap_q  <= '0;
        flag_q <= 1'b0;
      end else begin
        flag_q <= cap_hit[c];
        if (cap_hit[c]) cap_q <= cnt_q;
      end
    end
    assign cap_o[c]      = cap_q;
    assign cap_flag_o[c] = flag_q;
  end

  assign count_o   = cnt_q;
  assign running_o = run_q;
endmodule

// File: rtl/evq_timer.sv
module evq_timer #(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned N_TRIG      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_TRIG-1:0]     trig_i,
  input  logic                  pin_a_i,
  input  logic                  pin_b_i,
  input  logic [2*N_TRIG+7:0]   start_mask_i,
  input  logic [2*N_TRIG+7:0]   stop_mask_i,
  input  logic [2*N_TRIG+7:0]   clear_mask_i,
  input  logic [2*N_TRIG+7:0]   cap_a_mask_i,
  input  logic [2*N_TRIG+7:0]   cap_b_mask_i,
  input  logic [2*N_TRIG+7:0]   up_mask_i,
  input  logic [2*N_TRIG+7:0]   down_mask_i,
  output logic [CNT_W-1:0]      count_o,
  output logic                  running_o,
  output logic [CNT_W-1:0]      cap_a_o,
  output logic [CNT_W-1:0]      cap_b_o,
  output logic                  cap_a_flag_o,
  output logic                  cap_b_flag_o
);
  import evq_pkg::*;

  localparam int unsigned MASK_W = mask_width(N_TRIG);
  localparam int unsigned IN_W   = N_TRIG + 2;

  logic [IN_W-1:0]   in_s;
  logic [MASK_W-1:0] ev;

  evq_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pin_b_i, pin_a_i, trig_i}),
    .q_o   (in_s)
  );

  evq_edge_decode #(.N_TRIG(N_TRIG)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (in_s[N_TRIG-1:0]),
    .pin_a_i(in_s[N_TRIG]),
    .pin_b_i(in_s[N_TRIG+1]),
    .ev_o   (ev)
  );

  // mask slot order follows evq_act_t packing, msb first
  logic [MASK_W-1:0] masks [NUM_ACT];
  logic [NUM_ACT-1:0] hit;
  assign masks[6] = start_mask_i;
  assign masks[5] = stop_mask_i;
  assign masks[4] = clear_mask_i;
  assign masks[3] = cap_a_mask_i;
  assign masks[2] = cap_b_mask_i;
  assign masks[1] = up_mask_i;
  assign masks[0] = down_mask_i;

  for (genvar k = 0; k < NUM_ACT; k++) begin : g_hit
    evq_mask_hit #(.W(MASK_W)) u_hit (
      .mask_i(masks[k]),
      .ev_i  (ev),
      .hit_o (hit[k])
    );
  end

  evq_act_t act;
  assign act = evq_act_t'(hit);

  logic [CNT_W-1:0] cap [2];
  logic [1:0]       cap_flag;

  evq_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_i     (act),
    .clk_mode_i(~|{up_mask_i, down_mask_i}),
    .count_o   (count_o),
    .running_o (running_o),
    .cap_o     (cap),
    .cap_flag_o(cap_flag)
  );

  assign cap_a_o      = cap[0];
  assign cap_b_o      = cap[1];
  assign cap_a_flag_o = cap_flag[0];
  assign cap_b_flag_o = cap_flag[1];
endmodule

// File: rtl/evq_timer_chk.sv
module evq_timer_chk #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned N_TRIG = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [2*N_TRIG+7:0] clear_mask_i,
  input logic [2*N_TRIG+7:0] up_mask_i,
  input logic [2*N_TRIG+7:0] down_mask_i,
  input logic [CNT_W-1:0]    count_o,
  input logic                running_o,
  input logic [CNT_W-1:0]    cap_a_o,
  input logic [CNT_W-1:0]    cap_b_o,
  input logic                cap_a_flag_o,
  input logic                cap_b_flag_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (count_o == '0 && !running_o && !cap_a_flag_o && !cap_b_flag_o));

  // R6
  clock_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && up_mask_i == '0 && down_mask_i == '0 && clear_mask_i == '0)
      |=> count_o == $past(count_o) + ONE);

  // R7
  single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && (up_mask_i != '0 || down_mask_i != '0))
      |=> (count_o == $past(count_o) || count_o == $past(count_o) + ONE ||
           count_o == $past(count_o) - ONE || count_o == '0));

  // R9
  stopped_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_o |=> (count_o == $past(count_o) || count_o == '0));

  // R11
  cap_a_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_a_flag_o |-> cap_a_o == $past(count_o));

  // R11
  cap_b_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_b_flag_o |-> cap_b_o == $past(count_o));

  // R11
  cap_a_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_a_flag_o |-> $stable(cap_a_o));

  // R11
  cap_b_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_b_flag_o |-> $stable(cap_b_o));
endmodule

bind evq_timer evq_timer_chk #(.CNT_W(CNT_W), .N_TRIG(N_TRIG)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clear_mask_i(clear_mask_i),
  .up_mask_i   (up_mask_i),
  .down_mask_i (down_mask_i),
  .count_o     (count_o),
  .running_o   (running_o),
  .cap_a_o     (cap_a_o),
  .cap_b_o     (cap_b_o),
  .cap_a_flag_o(cap_a_flag_o),
  .cap_b_flag_o(cap_b_flag_o)
);

// File: tb/test_evq_timer.sv
module test_evq_timer;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  trig = '0;
  logic        pa = 1'b0, pb = 1'b0;
  logic [15:0] m_start = '0, m_stop = '0, m_clr = '0, m_ca = '0, m_cb = '0;
  logic [15:0] m_up = '0, m_dn = '0;
  logic [31:0] cnt, cap_a, cap_b;
  logic        run, fa, fb;

  int total = 0, bad = 0, fa_n = 0, fb_n = 0;
  bit done = 0;

  always #2 clk = ~clk;

  evq_timer i_evq_timer (
    .clk_i(clk), .rst_ni(rst_ni), .trig_i(trig), .pin_a_i(pa), .pin_b_i(pb),
    .start_mask_i(m_start), .stop_mask_i(m_stop), .clear_mask_i(m_clr),
    .cap_a_mask_i(m_ca), .cap_b_mask_i(m_cb), .up_mask_i(m_up), .down_mask_i(m_dn),
    .count_o(cnt), .running_o(run), .cap_a_o(cap_a), .cap_b_o(cap_b),
    .cap_a_flag_o(fa), .cap_b_flag_o(fb)
  );

  always @(negedge clk) begin
    if (fa) fa_n++;
    if (fb) fb_n++;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // sets up the preconditions for event ev, then raises it; returns the counter change
  task automatic fire(input int ev, output logic [31:0] delta);
    logic [31:0] c0;
    bit rise, oth_hi;
    if (ev < 8) begin
      rise = (ev % 2) == 0;
      trig[ev/2] = !rise;
      tick(5);
      c0 = cnt;
      trig[ev/2] = rise;
    end else begin
      rise   = ((ev - 8) % 4) < 2;
      oth_hi = ((ev - 8) % 2) == 1;
      if (ev < 12) begin pb = oth_hi; pa = !rise; end
      else         begin pa = oth_hi; pb = !rise; end
      tick(5);
      c0 = cnt;
      if (ev < 12) pa = rise; else pb = rise;
    end
    tick(5);
    delta = cnt - c0;
  endtask

  function automatic string grp(input int ev);
    return (ev < 8) ? "R2" : (ev < 12) ? "R3" : "R4";
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, c0;
    int fa0, fb0;
    tick(3);
    // R1 reset state
    chk("R1 count", cnt, 0);
    chk("R1 running", {31'b0, run}, 0);
    chk("R1 cap_a", cap_a, 0);
    chk("R1 cap_b", cap_b, 0);
    chk("R1 flags", {30'b0, fa, fb}, 0);
    rst_ni = 1'b1;
    tick(10);
    chk("R9 stopped hold", cnt, 0);

    // start on trigger 3 rising (bit 6); R12 latency
    m_start = 16'h0040;
    trig[3] = 1'b1;
    tick(2);
    chk("R12 not yet after 2 edges", {31'b0, run}, 0);
    tick(1);
    chk("R12 R9 started after 3 edges", {31'b0, run}, 1);
    c0 = cnt;
    tick(10);
    chk("R6 clock mode", cnt, c0 + 10);

    // stop and start on the same falling edge of trigger 3 (bit 7)
    m_start = 16'h00C0;
    m_stop  = 16'h0080;
    trig[3] = 1'b0;
    tick(3);
    chk("R9 stop wins", {31'b0, run}, 0);
    c0 = cnt;
    tick(8);
    chk("R9 hold when stopped", cnt, c0);
    m_start = '0; m_stop = '0;

    // clear while stopped (trigger 0 rising, bit 0)
    m_clr = 16'h0001;
    trig[0] = 1'b1;
    tick(3);
    chk("R10 clear stopped", cnt, 0);

    // clear while counting in clock mode
    m_start = 16'h0040;
    trig[3] = 1'b1;
    tick(3);
    m_start = '0;
    trig[0] = 1'b0;
    tick(6);
    trig[0] = 1'b1;
    tick(3);
    chk("R10 clear beats count", cnt, 0);
    tick(1);
    chk("R10 R6 counts after clear", cnt, 1);
    m_clr = '0;

    // sweeps: one mask bit against every event
    for (int b = 0; b < 16; b++) begin
      m_up = 16'(1 << b);
      for (int ev = 0; ev < 16; ev++) begin
        fire(ev, d);
        chk($sformatf("%s up bit%0d ev%0d", grp(ev), b, ev), d, (ev == b) ? 1 : 0);
      end
    end
    for (int b = 0; b < 16; b++) begin
      m_dn = 16'(1 << b);
      m_up = '0;
      for (int ev = 0; ev < 16; ev++) begin
        fire(ev, d);
        chk($sformatf("%s R7 down bit%0d ev%0d", grp(ev), b, ev), d,
            (ev == b) ? 32'hFFFF_FFFF : 0);
      end
    end

    // R5 two bits ORed
    m_up = 16'h0202;
    m_dn = '0;
    fire(1, d);  chk("R5 first source", d, 1);
    fire(9, d);  chk("R5 second source", d, 1);
    fire(2, d);  chk("R5 unselected", d, 0);

    // R8 up (trig0 rise) and down (trig1 rise) together
    m_up = 16'h0001;
    m_dn = 16'h0004;
    trig[0] = 1'b0; trig[1] = 1'b0;
    tick(5);
    c0 = cnt;
    trig[0] = 1'b1; trig[1] = 1'b1;
    tick(5);
    chk("R8 cancel", cnt, c0);

    // R7 wraparound: clear on trig2 rise, then step down and up
    m_clr = 16'h0010;
    trig[2] = 1'b0; tick(5);
    trig[2] = 1'b1; tick(5);
    chk("R10 clear event mode", cnt, 0);
    m_clr = '0;
    fire(2, d);
    chk("R7 wrap down", cnt, 32'hFFFF_FFFF);
    fire(0, d);
    chk("R7 wrap up", cnt, 0);

    // R11 captures
    fire(0, d); fire(0, d); fire(0, d);
    chk("R7 reach 3", cnt, 3);
    m_ca = 16'h0100;
    m_cb = 16'h1000;
    fa0 = fa_n; fb0 = fb_n;
    fire(8, d);
    chk("R11 cap_a value", cap_a, 3);
    chk("R11 cap_a one pulse", fa_n - fa0, 1);
    chk("R11 cap_b untouched", cap_b, 0);
    chk("R11 no cap_b pulse", fb_n - fb0, 0);
    fire(0, d);
    fire(12, d);
    chk("R11 cap_b value", cap_b, 4);
    chk("R11 cap_b one pulse", fb_n - fb0, 1);
    chk("R11 cap_a kept", cap_a, 3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule